// File: doc/BRIEF.md
# Additive Multiply Cell and Four-Cell Unsigned Multiplier

The basic building block is a small unsigned multiply cell. Besides the two factors it takes two extra addends of the same width. It returns their product plus both addends in a result twice the operand width. The cell is built from nothing but single-bit full adders and AND gates. Every partial-product bit is the AND of one bit of each factor. The partial products run through rows of full adders. One addend seeds the running sum before the first row. The bits of the other addend enter, one per row, as that row's carry-in.

The top level splits each wide operand into a high and a low half. It multiplies them with exactly four cells and nothing else between them. The cross terms and the carries fold into the cells' spare addend inputs, so no separate adder tree is needed. The whole path is combinational: no clock, no reset and no handshake. The result follows the operands after the settling delay of the full-adder array.

Top module: `amm_mul`

## Requirements
- R1: For every 4-bit unsigned a, x, b and y, the cell output p (8 bits) equals a*x + b + y.
- R2: The cell never overflows: a = x = b = y = 15 gives p = 255, the largest value 8 bits can hold.
- R3: With both addends held at zero, the cell output equals the plain product a*x.
- R4: For every pair of 8-bit unsigned operands, prod (16 bits) equals op_a*op_x.
- R5: When either operand is zero, prod is zero.
- R6: With both operands at 255, prod is 65025 (16'hFE01).
- R7: When one operand is 1, prod equals the other operand, zero-extended.
- R8: prod[3:0] equals the low four bits of op_a[3:0]*op_x[3:0], whatever the upper operand halves hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (8) | First unsigned factor |
| op_x | input | W (8) | Second unsigned factor |
| prod | output | 2*W (16) | Unsigned product, combinational |

## Verification
Two things can happen in the same settling pass. Inside a cell, a partial-product bit, the seeded sum bit and an addend carry-in can all land in one column. At the top, the upper halves of both cross-term cells can carry into the high cell together. The all-ones cases and the full sweeps bring about both collisions: every combination of the four cell inputs, then every operand pair of the multiplier. Each result is judged against a product and sum that the bench computes in integer arithmetic.

// File: rtl/amm_pkg.sv
package amm_pkg;
  localparam int unsigned CELL_BITS = 4;
  localparam int unsigned MUL_BITS  = 2 * CELL_BITS;
endpackage

// File: rtl/amm_fa.sv
module amm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/amm_cell.sv
module amm_cell #(
  parameter int unsigned N = amm_pkg::CELL_BITS
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   b,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] p
);
  localparam int unsigned PW = 2 * N;

  // running upper sum entering each row; row 0 is seeded by addend b
  logic [N-1:0] acc [0:N];
  assign acc[0] = b;

  for (genvar j = 0; j < N; j++) begin : g_row
    logic [N:0]   cy;
    logic [N-1:0] sm;
    assign cy[0] = y[j];          // second addend enters as row carry-in
    for (genvar i = 0; i < N; i++) begin : g_col
      amm_fa u_fa (
        .a_i (a[i] & x[j]),
        .b_i (acc[j][i]),
        .c_i (cy[i]),
        .s_o (sm[i]),
        .c_o (cy[i+1])
      );
    end
    assign p[j]     = sm[0];
    assign acc[j+1] = {cy[N], sm[N-1:1]};
  end

  assign p[PW-1:N] = acc[N];

  // R1: array result matches arithmetic multiply-add
  always_comb begin
    assert_cell_sum_R1: assert (p == ({{N{1'b0}}, a} * {{N{1'b0}}, x}
                                   + {{N{1'b0}}, b} + {{N{1'b0}}, y}))
      else $error("cell sum mismatch");
  end

  // R3: zero addends leave a plain product
  always_comb begin
    if (b == '0 && y == '0)
      assert_cell_plain_R3: assert (p == {{N{1'b0}}, a} * {{N{1'b0}}, x})
        else $error("cell plain product mismatch");
  end
endmodule

// File: rtl/amm_mul.sv
module amm_mul #(
  parameter int unsigned W = amm_pkg::MUL_BITS
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_x,
  output logic [2*W-1:0] prod
);
  localparam int unsigned H = W / 2;

  logic [H-1:0] a_lo, a_hi, x_lo, x_hi;
  logic [W-1:0] p_ll, p_hl, p_lh, p_hh;
  logic [H-1:0] zero_h;

  assign {a_hi, a_lo} = op_a;
  assign {x_hi, x_lo} = op_x;
  assign zero_h = '0;

  // low x low, no addends
  amm_cell #(.N(H)) u_ll (.a(a_lo), .x(x_lo), .b(zero_h),     .y(zero_h),     .p(p_ll));
  // high x low absorbs the upper half of the low product
  amm_cell #(.N(H)) u_hl (.a(a_hi), .x(x_lo), .b(p_ll[W-1:H]), .y(zero_h),    .p(p_hl));
  // low x high absorbs the lower half of the first cross term
  amm_cell #(.N(H)) u_lh (.a(a_lo), .x(x_hi), .b(p_hl[H-1:0]), .y(zero_h),    .p(p_lh));
  // high x high absorbs both cross-term upper halves
  amm_cell #(.N(H)) u_hh (.a(a_hi), .x(x_hi), .b(p_hl[W-1:H]), .y(p_lh[W-1:H]), .p(p_hh));

  assign prod = {p_hh, p_lh[H-1:0], p_ll[H-1:0]};

  // R4: composed product equals arithmetic product
  always_comb begin
    assert_prod_R4: assert (prod == {{W{1'b0}}, op_a} * {{W{1'b0}}, op_x})
      else $error("product mismatch");
  end

  // R5: zero operand annihilates
  always_comb begin
    if (op_a == '0 || op_x == '0)
      assert_zero_R5: assert (prod == '0) else $error("zero operand nonzero product");
  end

  // R7: unit operand passes the other through
  always_comb begin
    if (op_a == W'(1))
      assert_unit_R7: assert (prod == {{W{1'b0}}, op_x}) else $error("unit operand mismatch");
  end

  // R8: lowest nibble depends only on the low halves
  always_comb begin
    assert_low_nib_R8: assert (prod[H-1:0] == H'(a_lo * x_lo)) else $error("low nibble mismatch");
  end
endmodule

// File: tb/test_amm_mul.sv
module test_amm_mul;
  localparam int unsigned W = 8;
  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [W-1:0]   op_a, op_x;
  logic [2*W-1:0] prod;
  logic [N-1:0]   ca, cx, cb, cy;
  logic [2*N-1:0] cp;

  amm_mul #(.W(W)) i_amm_mul (.op_a(op_a), .op_x(op_x), .prod(prod));
  amm_cell #(.N(N)) i_amm_cell (.a(ca), .x(cx), .b(cb), .y(cy), .p(cp));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_mul(input int a, input int x);
    @(negedge clk);
    op_a = W'(a);
    op_x = W'(x);
    #5;
  endtask

  initial begin
    op_a = '0; op_x = '0; ca = '0; cx = '0; cb = '0; cy = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #5;
    check("R5 idle zero", int'(prod), 0);

    // R2 all-ones cell corner
    @(negedge clk); ca = 4'hF; cx = 4'hF; cb = 4'hF; cy = 4'hF; #5;
    check("R2 cell max", int'(cp), 255);

    // R1 and R3 exhaustive cell sweep
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      ca = k[3:0]; cx = k[7:4]; cb = k[11:8]; cy = k[15:12];
      #5;
      if (k[15:8] == 8'h00)
        check("R3 cell plain", int'(cp), k[3:0] * k[7:4]);
      else
        check("R1 cell sum", int'(cp), k[3:0] * k[7:4] + k[11:8] + k[15:12]);
    end

    // directed multiplier corners
    drive_mul(255, 255); check("R6 max product", int'(prod), 65025);
    drive_mul(0, 200);   check("R5 zero a", int'(prod), 0);
    drive_mul(173, 0);   check("R5 zero x", int'(prod), 0);
    drive_mul(1, 229);   check("R7 unit a", int'(prod), 229);
    drive_mul(94, 1);    check("R7 unit x", int'(prod), 94);
    drive_mul(8'hF7, 8'h03); check("R8 low nibble", int'(prod[3:0]), (7 * 3) % 16);

    // R4 exhaustive multiplier sweep
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      op_a = k[7:0]; op_x = k[15:8];
      #5;
      check("R4 product", int'(prod), k[7:0] * k[15:8]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule